// File: doc/BRIEF.md
# PMU System Control Register Block

This block is the system-control register set of a power-management controller. It sits behind a simple byte-wide register port and turns software writes and hardware events into one-cycle request pulses for the power sequencer: soft-reset, full power cycle, and all-outputs-off. It holds two watchdog action enables, an interrupt-source identifier register, pushbutton event status, a two-step guarded shutdown control, a delayed software power-cycle request, and sticky reset-cause flags.

Several registers have side effects that are tied to bus reads, sleep entry or write order. The identifier register returns to all-ones after it is read. Event status and reset-cause flags clear when they are read. Both watchdog enables drop to zero on sleep entry. Shutdown needs an arm write before the fire write. The software power cycle waits a fixed number of 1 us ticks (8000 by default, which is 8 ms) before it raises its request.

Top module: `pmu_sysctl`

## Requirements
- R1: After reset the register at offset 0x1 reads 0xFF, and offsets 0x0, 0x2 (with the button released), 0x3, 0x4 and 0x5 read 0x00. All request outputs are low.
- R2: Offset 0x0 is read/write, with bit 1 as the soft-reset watchdog enable and bit 0 as the power-cycle watchdog enable. When `wd_expire` is high with an enable set, the matching request (`srst_req` or `pcyc_req`) is high for one cycle, on the cycle after the expiry.
- R3: `sleep_enter` clears both watchdog enables at the next edge, and this takes priority over a write to offset 0x0 in the same cycle.
- R4: Offset 0x1 is read-only. It loads `irq_src_id` when `irq_src_valid` is high. A read returns the held value and restores 0xFF at that edge. A load in the same cycle as a read wins.
- R5: Bit 5 of offset 0x2 reads 1 while `btn_n` is low, delayed by the two-flop synchroniser, and 0 while it is high.
- R6: Bit 7 of offset 0x2 latches on a synchronised press (falling `btn_n`), and bit 6 latches on a synchronised release (rising `btn_n`). Both clear when offset 0x2 is read, unless a new event arrives in the same cycle.
- R7: At offset 0x3, bit 3 is the arm bit and bit 4 is the off trigger. A write with bit 4 set while the block is already armed produces one `off_req` pulse on the next cycle and disarms. A write with bit 4 set while not armed is ignored. Any write with bit 3 clear disarms. A read shows the arm state in bit 3, and bit 4 always reads 0.
- R8: Writing 1 to bit 0 of offset 0x4 starts a delay. `pcyc_req` pulses on the cycle after the DELAY_TICKS-th `tick_us` pulse that follows the write. Bit 0 reads 1 while the delay runs. A repeat write during the delay does not restart it.
- R9: Offset 0x5 holds the power-cycle flag in bit 1, set by `pcyc_done`, and the soft-reset flag in bit 0, set by `srst_done`. Both clear when offset 0x5 is read, and a set in the same cycle wins.
- R10: Reserved bits and unmapped offsets (0x6 to 0xF) read 0. Writes to them, and writes to read-only offsets 0x1, 0x2 and 0x5, change nothing.
- R11: `bus_rdata` is combinational and valid in the cycle `bus_rd` is high. It is 0x00 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at this edge) |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| tick_us | input | 1 | 1 us timebase enable |
| wd_expire | input | 1 | Watchdog expiry pulse |
| sleep_enter | input | 1 | Sleep entry pulse |
| btn_n | input | 1 | Pushbutton pin, active low, asynchronous |
| irq_src_valid | input | 1 | Load strobe for the interrupt source identifier |
| irq_src_id | input | 8 | Interrupt source identifier |
| srst_done | input | 1 | A soft-reset has completed |
| pcyc_done | input | 1 | A power cycle has completed |
| srst_req | output | 1 | Soft-reset request pulse |
| pcyc_req | output | 1 | Power-cycle request pulse |
| off_req | output | 1 | All-outputs-off request pulse |

## Verification
The bench drives the block with one kind of stimulus per area. Watchdog expiry is tried with each enable alone, with both enables, and with sleep entry in the same cycle as a write, which tells priority apart from plain clearing. The shutdown register sees off without arm, arm then off, arm then disarm then off, and arm and off in a single write, which separates "already armed" from "armed by this write". The button is pressed and released with reads between events, so set-versus-clear ordering shows up. The power-cycle delay runs with a sparse tick and a mid-delay rewrite, so a restart would show up as a late pulse.

// File: rtl/pmu_sysctl_pkg.sv
package pmu_sysctl_pkg;

    localparam logic [7:0] OFS_WDCTL = 8'h00;
    localparam logic [7:0] OFS_IRQID = 8'h01;
    localparam logic [7:0] OFS_BTN   = 8'h02;
    localparam logic [7:0] OFS_OFF   = 8'h03;
    localparam logic [7:0] OFS_PCYC  = 8'h04;
    localparam logic [7:0] OFS_FLAGS = 8'h05;

    localparam int BIT_WD_SRST  = 1;
    localparam int BIT_WD_PCYC  = 0;
    localparam int BIT_BTN_PRS  = 7;
    localparam int BIT_BTN_REL  = 6;
    localparam int BIT_BTN_LIVE = 5;
    localparam int BIT_OFF_FIRE = 4;
    localparam int BIT_OFF_ARM  = 3;
    localparam int BIT_PCYC_GO  = 0;
    localparam int BIT_FLG_PCYC = 1;
    localparam int BIT_FLG_SRST = 0;

    localparam logic [7:0] IRQID_IDLE = 8'hFF;

    typedef enum logic [2:0] {
        SEL_WDCTL,
        SEL_IRQID,
        SEL_BTN,
        SEL_OFF,
        SEL_PCYC,
        SEL_FLAGS,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic srst_en;
        logic pcyc_en;
    } wd_cfg_t;

    typedef struct packed {
        logic level;
        logic press;
        logic release_;
    } btn_evt_t;

    typedef struct packed {
        logic pcyc;
        logic srst;
    } rst_flags_t;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_WDCTL: return SEL_WDCTL;
            OFS_IRQID: return SEL_IRQID;
            OFS_BTN:   return SEL_BTN;
            OFS_OFF:   return SEL_OFF;
            OFS_PCYC:  return SEL_PCYC;
            OFS_FLAGS: return SEL_FLAGS;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] place_bit(input int pos, input logic val);
        logic [7:0] r;
        r = '0;
        r[pos] = val;
        return r;
    endfunction

endpackage

// File: rtl/pmu_sysctl_btnsync.sv
module pmu_sysctl_btnsync
    import pmu_sysctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_n,
    output btn_evt_t evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= pin_n;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b1;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[LAST];
    end

    always_comb begin
        evt.level    = ~chain_q[LAST];
        evt.press    = prev_q & ~chain_q[LAST];
        evt.release_ = ~prev_q & chain_q[LAST];
    end

endmodule

// File: rtl/pmu_sysctl_pcdelay.sv
module pmu_sysctl_pcdelay #(
    parameter int DELAY_TICKS = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic pending,
    output logic done
);
    localparam int CNT_W = $clog2(DELAY_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_TICKS - 1);

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == CNT_LAST);
    assign pending = pend_q;
    assign done    = pend_q & tick & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!pend_q) begin
            if (start) begin
                pend_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (tick) begin
            if (at_last) begin
                pend_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pmu_sysctl_offguard.sv
module pmu_sysctl_offguard (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic arm_bit,
    input  logic fire_bit,
    output logic armed,
    output logic fire
);
    logic armed_q;
    logic fire_q;
    logic fire_now;

    assign fire_now = wr & fire_bit & armed_q;
    assign armed    = armed_q;
    assign fire     = fire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= fire_now;
            if (wr) armed_q <= arm_bit & ~fire_now;
        end
    end

endmodule

// File: rtl/pmu_sysctl.sv
module pmu_sysctl
    import pmu_sysctl_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DELAY_TICKS = 8000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tick_us,
    input  logic              wd_expire,
    input  logic              sleep_enter,
    input  logic              btn_n,
    input  logic              irq_src_valid,
    input  logic [7:0]        irq_src_id,
    input  logic              srst_done,
    input  logic              pcyc_done,
    output logic              srst_req,
    output logic              pcyc_req,
    output logic              off_req
);
    reg_sel_e   sel;
    logic       wr_wd, wr_off, wr_pcyc;
    logic       rd_irq, rd_btn, rd_flags;

    wd_cfg_t    wd_q;
    logic [7:0] irq_id_q;
    logic       prs_q, rel_q;
    rst_flags_t flags_q;
    logic       srst_req_q, pcyc_req_q;

    btn_evt_t   bev;
    logic       off_armed, off_fire;
    logic       pc_pending, pc_done;

    assign sel      = decode_ofs(8'(bus_addr));
    assign wr_wd    = bus_wr && (sel == SEL_WDCTL);
    assign wr_off   = bus_wr && (sel == SEL_OFF);
    assign wr_pcyc  = bus_wr && (sel == SEL_PCYC);
    assign rd_irq   = bus_rd && (sel == SEL_IRQID);
    assign rd_btn   = bus_rd && (sel == SEL_BTN);
    assign rd_flags = bus_rd && (sel == SEL_FLAGS);

    pmu_sysctl_btnsync #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
        .clk   (clk),
        .rst   (rst),
        .pin_n (btn_n),
        .evt   (bev)
    );

    pmu_sysctl_offguard u_off (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_off),
        .arm_bit  (bus_wdata[BIT_OFF_ARM]),
        .fire_bit (bus_wdata[BIT_OFF_FIRE]),
        .armed    (off_armed),
        .fire     (off_fire)
    );

    pmu_sysctl_pcdelay #(.DELAY_TICKS(DELAY_TICKS)) u_pcd (
        .clk     (clk),
        .rst     (rst),
        .start   (wr_pcyc & bus_wdata[BIT_PCYC_GO]),
        .tick    (tick_us),
        .pending (pc_pending),
        .done    (pc_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_q <= '0;
        end else if (sleep_enter) begin
            wd_q <= '0;
        end else if (wr_wd) begin
            wd_q.srst_en <= bus_wdata[BIT_WD_SRST];
            wd_q.pcyc_en <= bus_wdata[BIT_WD_PCYC];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_req_q <= 1'b0;
            pcyc_req_q <= 1'b0;
        end else begin
            srst_req_q <= wd_expire & wd_q.srst_en;
            pcyc_req_q <= (wd_expire & wd_q.pcyc_en) | pc_done;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                irq_id_q <= IRQID_IDLE;
        else if (irq_src_valid) irq_id_q <= irq_src_id;
        else if (rd_irq)        irq_id_q <= IRQID_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prs_q <= 1'b0;
            rel_q <= 1'b0;
        end else begin
            prs_q <= bev.press    | (prs_q & ~rd_btn);
            rel_q <= bev.release_ | (rel_q & ~rd_btn);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.pcyc <= pcyc_done | (flags_q.pcyc & ~rd_flags);
            flags_q.srst <= srst_done | (flags_q.srst & ~rd_flags);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_WDCTL: bus_rdata = place_bit(BIT_WD_SRST, wd_q.srst_en)
                                     | place_bit(BIT_WD_PCYC, wd_q.pcyc_en);
                SEL_IRQID: bus_rdata = irq_id_q;
                SEL_BTN:   bus_rdata = place_bit(BIT_BTN_PRS, prs_q)
                                     | place_bit(BIT_BTN_REL, rel_q)
                                     | place_bit(BIT_BTN_LIVE, bev.level);
                SEL_OFF:   bus_rdata = place_bit(BIT_OFF_ARM, off_armed);
                SEL_PCYC:  bus_rdata = place_bit(BIT_PCYC_GO, pc_pending);
                SEL_FLAGS: bus_rdata = place_bit(BIT_FLG_PCYC, flags_q.pcyc)
                                     | place_bit(BIT_FLG_SRST, flags_q.srst);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign srst_req = srst_req_q;
    assign pcyc_req = pcyc_req_q;
    assign off_req  = off_fire;

endmodule

// File: rtl/pmu_sysctl_chk.sv
module pmu_sysctl_chk
    import pmu_sysctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              wd_expire,
    input logic              sleep_enter,
    input logic              irq_src_valid,
    input logic              srst_req,
    input logic              pcyc_req,
    input logic              off_req,
    input logic [1:0]        wd_bits,
    input logic [7:0]        irq_id,
    input logic              armed,
    input logic              pending
);
    logic [7:0] a8;
    assign a8 = 8'(bus_addr);

    assert_srst_cause_R2: assert property (@(posedge clk) disable iff (rst)
        srst_req |-> $past(wd_expire));

    assert_sleep_clear_R3: assert property (@(posedge clk) disable iff (rst)
        sleep_enter |=> (wd_bits == 2'b00));

    assert_irq_restore_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && a8 == OFS_IRQID && !irq_src_valid) |=> (irq_id == IRQID_IDLE));

    assert_off_order_R7: assert property (@(posedge clk) disable iff (rst)
        off_req |-> ($past(armed) && $past(bus_wr) && $past(a8) == OFS_OFF
                     && $past(bus_wdata[BIT_OFF_FIRE])));

    assert_pcyc_cause_R8: assert property (@(posedge clk) disable iff (rst)
        pcyc_req |-> ($past(wd_expire) || $past(pending)));

    assert_start_pending_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a8 == OFS_PCYC && bus_wdata[BIT_PCYC_GO] && !pending) |=> pending);

    assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && a8 == OFS_WDCTL) |-> (bus_rdata[7:2] == 6'd0));

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 8'h00));

endmodule

bind pmu_sysctl pmu_sysctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .wd_expire     (wd_expire),
    .sleep_enter   (sleep_enter),
    .irq_src_valid (irq_src_valid),
    .srst_req      (srst_req),
    .pcyc_req      (pcyc_req),
    .off_req       (off_req),
    .wd_bits       ({wd_q.srst_en, wd_q.pcyc_en}),
    .irq_id        (irq_id_q),
    .armed         (off_armed),
    .pending       (pc_pending)
);

// File: tb/pmu_sysctl_tb.sv
`timescale 1ns/1ps
module pmu_sysctl_tb;
    localparam int ADDR_W = 4;
    localparam int DELAY  = 8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 0, bus_rd = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic tick_us = 0, wd_expire = 0, sleep_enter = 0, btn_n = 1;
    logic irq_src_valid = 0;
    logic [7:0] irq_src_id = '0;
    logic srst_done = 0, pcyc_done = 0;
    logic srst_req, pcyc_req, off_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pmu_sysctl #(.ADDR_W(ADDR_W), .DELAY_TICKS(DELAY)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_us(tick_us), .wd_expire(wd_expire), .sleep_enter(sleep_enter),
        .btn_n(btn_n), .irq_src_valid(irq_src_valid), .irq_src_id(irq_src_id),
        .srst_done(srst_done), .pcyc_done(pcyc_done),
        .srst_req(srst_req), .pcyc_req(pcyc_req), .off_req(off_req)
    );

    // behavioural reference state
    bit m_wds, m_wdp, m_prs, m_rel, m_arm, m_pend, m_pcf, m_srf;
    bit m_s1, m_s2, m_s3, m_srq, m_pcq, m_offq;
    int m_irq, m_cnt;

    function automatic string tag_for(input int a);
        case (a)
            0: return "R2";
            1: return "R4";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int m_rdata();
        int a = int'(bus_addr);
        if (!bus_rd) return 0;
        case (a)
            0: return (int'(m_wds) << 1) | int'(m_wdp);
            1: return m_irq;
            2: return (int'(m_prs) << 7) | (int'(m_rel) << 6) | (int'(!m_s2) << 5);
            3: return int'(m_arm) << 3;
            4: return int'(m_pend);
            5: return (int'(m_pcf) << 1) | int'(m_srf);
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_wds = 0; m_wdp = 0; m_prs = 0; m_rel = 0; m_arm = 0; m_pend = 0;
        m_pcf = 0; m_srf = 0; m_s1 = 1; m_s2 = 1; m_s3 = 1;
        m_srq = 0; m_pcq = 0; m_offq = 0; m_irq = 255; m_cnt = 0;
    endtask

    task automatic model_step();
        int a = int'(bus_addr);
        bit w0 = bus_wr && a == 0, w3 = bus_wr && a == 3, w4 = bus_wr && a == 4;
        bit r1 = bus_rd && a == 1, r2 = bus_rd && a == 2, r5 = bus_rd && a == 5;
        bit prs_ev = m_s3 && !m_s2, rel_ev = !m_s3 && m_s2;
        bit fin = m_pend && tick_us && (m_cnt == DELAY - 1);
        bit fire = w3 && bus_wdata[4] && m_arm;
        if (rst) begin model_reset(); return; end
        m_srq = wd_expire && m_wds;
        m_pcq = (wd_expire && m_wdp) || fin;
        m_offq = fire;
        if (w3) m_arm = bus_wdata[3] && !fire;
        if (sleep_enter) begin m_wds = 0; m_wdp = 0; end
        else if (w0) begin m_wds = bus_wdata[1]; m_wdp = bus_wdata[0]; end
        if (irq_src_valid) m_irq = int'(irq_src_id);
        else if (r1) m_irq = 255;
        m_prs = prs_ev || (m_prs && !r2);
        m_rel = rel_ev || (m_rel && !r2);
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = btn_n;
        if (!m_pend) begin
            if (w4 && bus_wdata[0]) begin m_pend = 1; m_cnt = 0; end
        end else if (tick_us) begin
            if (fin) begin m_pend = 0; m_cnt = 0; end
            else m_cnt++;
        end
        m_pcf = pcyc_done || (m_pcf && !r5);
        m_srf = srst_done || (m_srf && !r5);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // one clock: compare read data, clock the edge, compare registered outputs
    task automatic cyc();
        #1;
        if (bus_rd) chk((rst ? "R1" : tag_for(int'(bus_addr))), "rdata", int'(bus_rdata), m_rdata());
        else        chk("R11", "idle rdata", int'(bus_rdata), 0);
        @(posedge clk);
        model_step();
        #1;
        chk("R2", "srst_req", int'(srst_req), int'(m_srq));
        chk("R8", "pcyc_req", int'(pcyc_req), int'(m_pcq));
        chk("R7", "off_req", int'(off_req), int'(m_offq));
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; wd_expire = 0; sleep_enter = 0;
        irq_src_valid = 0; srst_done = 0; pcyc_done = 0; tick_us = 0;
    endtask

    task automatic wr(input int a, input int d);
        idle(); bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = 8'(d); cyc(); idle();
    endtask

    task automatic rd(input int a);
        idle(); bus_rd = 1; bus_addr = ADDR_W'(a); cyc(); idle();
    endtask

    task automatic rd_expect(input string req, input int a, input int exp);
        idle(); bus_rd = 1; bus_addr = ADDR_W'(a);
        #1 chk(req, "explicit read", int'(bus_rdata), exp);
        cyc(); idle();
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) begin idle(); cyc(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired before the test completed");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        idle(); rst = 1; cyc(); cyc(); rst = 0;

        // R1 reset values
        rd_expect("R1", 1, 8'hFF);
        rd_expect("R1", 0, 0);
        rd_expect("R1", 2, 0);
        rd_expect("R1", 3, 0);
        rd_expect("R1", 4, 0);
        rd_expect("R1", 5, 0);

        // R2 watchdog enables and requests
        wr(0, 8'h02); rd_expect("R2", 0, 8'h02);
        idle(); wd_expire = 1; cyc(); idle(); cyc();
        wr(0, 8'h01); idle(); wd_expire = 1; cyc(); nop(1);
        wr(0, 8'hFF); rd_expect("R2", 0, 8'h03);
        idle(); wd_expire = 1; cyc(); nop(1);

        // R3 sleep clears enables, beats same-cycle write
        idle(); sleep_enter = 1; cyc(); rd_expect("R3", 0, 0);
        idle(); bus_wr = 1; bus_addr = 0; bus_wdata = 8'h03; sleep_enter = 1; cyc();
        rd_expect("R3", 0, 0);
        idle(); wd_expire = 1; cyc(); nop(1);

        // R4 interrupt source identifier
        idle(); irq_src_valid = 1; irq_src_id = 8'h3C; cyc();
        rd_expect("R4", 1, 8'h3C); rd_expect("R4", 1, 8'hFF);
        idle(); irq_src_valid = 1; irq_src_id = 8'h11; cyc();
        idle(); bus_rd = 1; bus_addr = 1; irq_src_valid = 1; irq_src_id = 8'h22; cyc();
        rd_expect("R4", 1, 8'h22);

        // R5 / R6 pushbutton
        btn_n = 0; nop(1); rd_expect("R5", 2, 8'h00);
        nop(2); rd_expect("R6", 2, 8'hA0);
        rd_expect("R6", 2, 8'h20);
        btn_n = 1; nop(4); rd_expect("R6", 2, 8'h40);
        rd_expect("R5", 2, 8'h00);
        btn_n = 0; nop(3); btn_n = 1; nop(4); rd_expect("R6", 2, 8'hC0);
        // pulse too short to pass twice stays tracked by model
        btn_n = 0; nop(1); btn_n = 1; nop(5); rd(2);

        // R7 guarded shutdown
        wr(3, 8'h10); nop(1);
        wr(3, 8'h08); rd_expect("R7", 3, 8'h08);
        wr(3, 8'h18); nop(1); rd_expect("R7", 3, 8'h00);
        wr(3, 8'h08); wr(3, 8'h00); wr(3, 8'h10); nop(1);
        wr(3, 8'h18); wr(3, 8'h18); nop(1);
        wr(3, 8'h08); wr(5, 8'hFF); wr(3, 8'h18); nop(1);

        // R10 unmapped and read-only writes
        wr(6, 8'hFF); rd_expect("R10", 6, 0);
        wr(15, 8'hFF); rd_expect("R10", 15, 0);
        wr(1, 8'h00); rd_expect("R10", 1, 8'hFF);
        wr(2, 8'hFF); rd_expect("R10", 2, 8'h00);

        // R9 reset-cause flags
        idle(); pcyc_done = 1; cyc(); rd_expect("R9", 5, 8'h02); rd_expect("R9", 5, 8'h00);
        idle(); srst_done = 1; cyc();
        idle(); bus_rd = 1; bus_addr = 5; pcyc_done = 1; cyc();
        rd_expect("R9", 5, 8'h02);

        // R8 delayed software power cycle, sparse tick and mid-delay rewrite
        wr(4, 8'h01); rd_expect("R8", 4, 8'h01);
        for (int i = 0; i < DELAY * 3 + 20; i++) begin
            idle();
            tick_us = (i % 3 == 0);
            if (i == 300) begin bus_wr = 1; bus_addr = 4; bus_wdata = 8'h01; end
            cyc();
        end
        rd_expect("R8", 4, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule